// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Engine

This block runs one DMA channel over a chain of descriptors kept in a small descriptor memory. Each descriptor is four consecutive words: link to the next descriptor, buffer address, buffer length, and a control/status word. Software builds a chain, hands each descriptor to the hardware by setting its owner bit, enables the channel's direction and writes the address of the first descriptor into the head register. The engine fetches each descriptor, puts the buffer address and length on a request/done handshake to a separate data mover, and writes status back into the control/status word once that transfer finishes. It then follows the link.

Handoff between software and hardware uses only bits in the control/status word. The engine releases a descriptor by clearing its owner bit. It flags the end of a chain with an end-of-queue bit, so that software can see that a descriptor linked too late was missed and can restart the chain through the head register. Software acknowledges finished descriptors through a completion register. An interrupt line is raised while that register disagrees with the last descriptor the engine finished. Software can also abort the channel with a teardown request, and a soft-reset command clears the channel.

Top module: `desc_dma_chan`

## Requirements
- R1: After reset, irq and xfer_req are 0, the control, head and completion registers and the soft-reset status read 0, and no descriptor memory access is made.
- R2: The channel walks descriptors only while bit 0 of its own direction's control register is 1. With IS_RX=0 that is offset 0. A write of 1 to the other direction's control register (offset 1) starts nothing. A head value written while the channel is disabled is held, can be read back, and is processed once the channel is enabled.
- R3: A nonzero value written to the head register (offset 2) while the engine is idle makes it read words A..A+3 as link, buffer address, buffer length and control/status word. If the owner bit (bit 29) is 1, the engine then raises xfer_req with xfer_addr = buffer address and xfer_len = buffer length, and holds xfer_req until xfer_done.
- R4: On xfer_done the control/status word is written back with the owner bit cleared and bits 31..11 otherwise unchanged. Bits 10..0 are set to xfer_done_len, plus 4 (modulo 2^11) when the pass-CRC bit 26 is set.
- R5: A nonzero link makes the engine go on to the linked descriptor. A zero link also sets end-of-queue (bit 28) in the written-back word, after which the head register reads 0 and the engine goes idle.
- R6: A fetched descriptor whose owner bit is 0 is not transferred and is left unchanged. The engine sets end-of-queue on the previously finished descriptor instead, clears the head register and goes idle.
- R7: After an end-of-queue stop, writing the head register with the address of a newly owned descriptor resumes processing from it.
- R8: Writing the value CHAN_ID to the teardown register (offset 4) stops the channel. The descriptor in transfer, or otherwise the next one fetched, is written back with the owner bit clear and with teardown-complete (bit 27) and end-of-queue set. The completion register (offset 3) then reads 0xFFFFFFFC and the head register reads 0. With an empty queue, the completion register takes that value at once. Any other value written to offset 4 has no effect.
- R9: irq is 1 exactly when the completion register differed, one cycle earlier, from the address of the last descriptor finished. Writing that address to the completion register drops irq.
- R10: Writing 1 to the soft-reset register (offset 5) makes it read 1 for SRST_CYC cycles and then 0. At that point the control, head and completion registers read 0 and irq is 0.
- R11: A head-register write made while the engine is walking a chain is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; data appears the next cycle |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| dm_en | output | 1 | Descriptor memory access enable |
| dm_we | output | 1 | Descriptor memory write enable |
| dm_addr | output | DM_AW | Descriptor memory word address |
| dm_wdata | output | 32 | Descriptor memory write data |
| dm_rdata | input | 32 | Descriptor memory read data, one cycle after the read |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_addr | output | 32 | Buffer address of the current descriptor |
| xfer_len | output | LEN_W | Buffer length of the current descriptor |
| xfer_done | input | 1 | One-cycle pulse: transfer finished |
| xfer_done_len | input | 11 | Packet length reported with xfer_done |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with DM_AW=6, LEN_W=16, CHAN_ID=2, IS_RX=0 and SRST_CYC=4. A 64-word descriptor memory keeps every chain small enough to model as a plain array. With these values the bench can sweep every chain length from one to four, each with two length patterns. One pattern covers a zero length, where the reported length wraps through the 11-bit field with the CRC adjustment. It can also reach every teardown and owner-clear path within a few hundred cycles each. The short soft-reset count lets the busy window be read out from start to end.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  // control/status word bit positions (software decodes these)
  localparam int B_SOP = 31;
  localparam int B_EOP = 30;
  localparam int B_OWN = 29;
  localparam int B_EOQ = 28;
  localparam int B_TDC = 27;
  localparam int B_CRC = 26;
  localparam int PLEN_W = 11;
  localparam int CRC_BYTES = 4;
  localparam int DESC_WORDS = 4;
  localparam int MODE_OFS = 3;
  localparam logic [31:0] TD_MAGIC = 32'hFFFF_FFFC;

  // register offsets
  localparam logic [2:0] RA_TXCTL = 3'd0;
  localparam logic [2:0] RA_RXCTL = 3'd1;
  localparam logic [2:0] RA_HEAD  = 3'd2;
  localparam logic [2:0] RA_COMPL = 3'd3;
  localparam logic [2:0] RA_TDOWN = 3'd4;
  localparam logic [2:0] RA_SRST  = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_XFER, S_WB
  } walk_state_t;
endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int CHAN_ID  = 2,
  parameter bit IS_RX    = 1'b0,
  parameter int SRST_CYC = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [31:0] head_q,
  input  logic [31:0] last_done,
  input  logic        td_done,
  output logic        chan_en,
  output logic        head_wr,
  output logic        td_pend,
  output logic        eng_clr,
  output logic        irq
);
  localparam int SRW = $clog2(SRST_CYC + 1);

  logic           tx_en, rx_en;
  logic [31:0]    cp_q;
  logic [SRW-1:0] sr_cnt;

  assign eng_clr = (sr_cnt == SRW'(1));
  assign head_wr = reg_we && (reg_addr == RA_HEAD);

  generate
    if (IS_RX) begin : g_rx
      assign chan_en = rx_en;
    end else begin : g_tx
      assign chan_en = tx_en;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || eng_clr) begin
      tx_en   <= 1'b0;
      rx_en   <= 1'b0;
      cp_q    <= '0;
      td_pend <= 1'b0;
      sr_cnt  <= '0;
      irq     <= 1'b0;
    end else begin
      if (sr_cnt != '0) sr_cnt <= sr_cnt - SRW'(1);
      if (td_done) td_pend <= 1'b0;
      if (reg_we) begin
        case (reg_addr)
          RA_TXCTL: tx_en <= reg_wdata[0];
          RA_RXCTL: rx_en <= reg_wdata[0];
          RA_COMPL: cp_q  <= reg_wdata;
          RA_TDOWN: if (reg_wdata == 32'(CHAN_ID)) td_pend <= 1'b1;
          RA_SRST:  if (reg_wdata[0] && sr_cnt == '0) sr_cnt <= SRW'(SRST_CYC);
          default: ;
        endcase
      end
      if (td_done) cp_q <= TD_MAGIC;
      irq <= (cp_q != last_done);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_re) begin
      case (reg_addr)
        RA_TXCTL: reg_rdata <= {31'd0, tx_en};
        RA_RXCTL: reg_rdata <= {31'd0, rx_en};
        RA_HEAD:  reg_rdata <= head_q;
        RA_COMPL: reg_rdata <= cp_q;
        RA_SRST:  reg_rdata <= {31'd0, (sr_cnt != '0)};
        default:  reg_rdata <= '0;
      endcase
    end
  end

  assert_td_magic_R8: assert property (@(posedge clk) disable iff (rst)
    (td_done && !eng_clr) |=> (cp_q == TD_MAGIC));

  assert_td_other_id_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == RA_TDOWN && reg_wdata != 32'(CHAN_ID) && !td_pend)
      |=> !td_pend);

  assert_srst_clears_R10: assert property (@(posedge clk) disable iff (rst)
    eng_clr |=> (!tx_en && !rx_en && cp_q == '0 && !irq));
endmodule

// File: rtl/dmach_walk.sv
module dmach_walk
  import dmach_pkg::*;
#(
  parameter int DM_AW = 6,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              head_wr,
  input  logic [31:0]       head_wdata,
  input  logic              td_pend,
  output logic [31:0]       head_q,
  output logic [31:0]       last_done,
  output logic              td_done,
  output logic              dm_en,
  output logic              dm_we,
  output logic [DM_AW-1:0]  dm_addr,
  output logic [31:0]       dm_wdata,
  input  logic [31:0]       dm_rdata,
  output logic              xfer_req,
  output logic [31:0]       xfer_addr,
  output logic [LEN_W-1:0]  xfer_len,
  input  logic              xfer_done,
  input  logic [PLEN_W-1:0] xfer_done_len
);
  localparam int CW = $clog2(DESC_WORDS + 1);

  walk_state_t       st;
  logic [CW-1:0]     cnt;
  logic [31:0]       cur, d_next, d_buf, d_len, d_mode;
  logic [31:0]       prev_addr, prev_mode, wb_mode;
  logic              have_prev, td_mark, td_go;
  logic [PLEN_W-1:0] rep_len;

  assign td_go = td_pend && !td_done;

  always_comb begin
    wb_mode = {d_mode[31:PLEN_W], rep_len};
    wb_mode[B_OWN] = 1'b0;
    if (td_mark) begin
      wb_mode[B_TDC] = 1'b1;
      wb_mode[B_EOQ] = 1'b1;
    end
    if (d_next == '0) wb_mode[B_EOQ] = 1'b1;
  end

  always_comb begin
    dm_en    = 1'b0;
    dm_we    = 1'b0;
    dm_addr  = cur[DM_AW-1:0];
    dm_wdata = wb_mode;
    case (st)
      S_FETCH: if (cnt < CW'(DESC_WORDS)) begin
        dm_en   = 1'b1;
        dm_addr = cur[DM_AW-1:0] + DM_AW'(cnt);
      end
      S_CHECK: if (!td_go && !d_mode[B_OWN] && have_prev) begin
        dm_en    = 1'b1;
        dm_we    = 1'b1;
        dm_addr  = prev_addr[DM_AW-1:0] + DM_AW'(MODE_OFS);
        dm_wdata = prev_mode | (32'd1 << B_EOQ);
      end
      S_WB: begin
        dm_en   = 1'b1;
        dm_we   = 1'b1;
        dm_addr = cur[DM_AW-1:0] + DM_AW'(MODE_OFS);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      cnt <= '0;
      cur <= '0;
      d_next <= '0;
      d_buf <= '0;
      d_len <= '0;
      d_mode <= '0;
      prev_addr <= '0;
      prev_mode <= '0;
      have_prev <= 1'b0;
      td_mark <= 1'b0;
      rep_len <= '0;
      head_q <= '0;
      last_done <= '0;
      td_done <= 1'b0;
      xfer_req <= 1'b0;
      xfer_addr <= '0;
      xfer_len <= '0;
    end else begin
      td_done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (head_wr) head_q <= head_wdata;
          if (td_go) begin
            if (head_q != '0) begin
              cur <= head_q;
              cnt <= '0;
              st  <= S_FETCH;
            end else begin
              td_done <= 1'b1;
            end
          end else if (!head_wr && en && head_q != '0) begin
            cur <= head_q;
            cnt <= '0;
            st  <= S_FETCH;
          end
        end
        S_FETCH: begin
          case (cnt)
            CW'(1): d_next <= dm_rdata;
            CW'(2): d_buf  <= dm_rdata;
            CW'(3): d_len  <= dm_rdata;
            CW'(4): d_mode <= dm_rdata;
            default: ;
          endcase
          if (cnt == CW'(DESC_WORDS)) st <= S_CHECK;
          else cnt <= cnt + CW'(1);
        end
        S_CHECK: begin
          if (td_go) begin
            td_mark <= 1'b1;
            rep_len <= d_mode[PLEN_W-1:0];
            st      <= S_WB;
          end else if (!d_mode[B_OWN]) begin
            head_q <= '0;
            st     <= S_IDLE;
          end else begin
            xfer_req  <= 1'b1;
            xfer_addr <= d_buf;
            xfer_len  <= d_len[LEN_W-1:0];
            st        <= S_XFER;
          end
        end
        S_XFER: begin
          if (xfer_done) begin
            xfer_req <= 1'b0;
            rep_len  <= xfer_done_len +
                        (d_mode[B_CRC] ? PLEN_W'(CRC_BYTES) : PLEN_W'(0));
            td_mark  <= td_go;
            st       <= S_WB;
          end
        end
        S_WB: begin
          td_mark <= 1'b0;
          if (td_mark) begin
            head_q    <= '0;
            td_done   <= 1'b1;
            have_prev <= 1'b0;
            st        <= S_IDLE;
          end else begin
            last_done <= cur;
            prev_addr <= cur;
            prev_mode <= wb_mode;
            have_prev <= 1'b1;
            if (d_next == '0) begin
              head_q <= '0;
              st     <= S_IDLE;
            end else begin
              head_q <= d_next;
              cur    <= d_next;
              cnt    <= '0;
              st     <= S_FETCH;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !xfer_done) |=> xfer_req);

  assert_idle_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !en && !td_go) |=> (st != S_FETCH));

  assert_eoq_end_R5: assert property (@(posedge clk) disable iff (rst)
    (st == S_WB && !td_mark && d_next == '0) |=> (head_q == '0 && st == S_IDLE));

  assert_owner_skip_R6: assert property (@(posedge clk) disable iff (rst)
    (st == S_CHECK && !td_go && !d_mode[B_OWN]) |=> !xfer_req);

  assert_busy_head_R11: assert property (@(posedge clk) disable iff (rst)
    (st == S_XFER && !xfer_done && head_wr) |=> (head_q == $past(head_q)));
endmodule

// File: rtl/desc_dma_chan.sv
module desc_dma_chan
  import dmach_pkg::*;
#(
  parameter int CHAN_ID  = 2,
  parameter bit IS_RX    = 1'b0,
  parameter int DM_AW    = 6,
  parameter int LEN_W    = 16,
  parameter int SRST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              dm_en,
  output logic              dm_we,
  output logic [DM_AW-1:0]  dm_addr,
  output logic [31:0]       dm_wdata,
  input  logic [31:0]       dm_rdata,
  output logic              xfer_req,
  output logic [31:0]       xfer_addr,
  output logic [LEN_W-1:0]  xfer_len,
  input  logic              xfer_done,
  input  logic [PLEN_W-1:0] xfer_done_len,
  output logic              irq
);
  logic [31:0] head_q, last_done;
  logic        td_done, chan_en, head_wr, td_pend, eng_clr, walk_rst;

  assign walk_rst = rst || eng_clr;

  dmach_regs #(.CHAN_ID(CHAN_ID), .IS_RX(IS_RX), .SRST_CYC(SRST_CYC)) regs_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .head_q(head_q),
    .last_done(last_done), .td_done(td_done), .chan_en(chan_en),
    .head_wr(head_wr), .td_pend(td_pend), .eng_clr(eng_clr), .irq(irq)
  );

  dmach_walk #(.DM_AW(DM_AW), .LEN_W(LEN_W)) walk_i (
    .clk(clk), .rst(walk_rst), .en(chan_en), .head_wr(head_wr),
    .head_wdata(reg_wdata), .td_pend(td_pend), .head_q(head_q),
    .last_done(last_done), .td_done(td_done), .dm_en(dm_en), .dm_we(dm_we),
    .dm_addr(dm_addr), .dm_wdata(dm_wdata), .dm_rdata(dm_rdata),
    .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .xfer_done(xfer_done), .xfer_done_len(xfer_done_len)
  );
endmodule

// File: tb/desc_dma_chan_tb_top.sv
`timescale 1ns/1ps
module desc_dma_chan_tb_top;
  localparam int DM_AW = 6, LEN_W = 16, CHAN_ID = 2, SRST_CYC = 4;
  localparam logic [31:0] OWN = 32'h2000_0000, EOQ = 32'h1000_0000,
                          TDC = 32'h0800_0000, CRC = 32'h0400_0000,
                          SE  = 32'hC000_0000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic reg_we = 0, reg_re = 0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic dm_en, dm_we;
  logic [DM_AW-1:0] dm_addr;
  logic [31:0] dm_wdata, dm_rdata;
  logic xfer_req;
  logic [31:0] xfer_addr;
  logic [LEN_W-1:0] xfer_len;
  logic xfer_done = 0;
  logic [10:0] xfer_done_len = '0;
  logic irq;

  desc_dma_chan #(.CHAN_ID(CHAN_ID), .IS_RX(1'b0), .DM_AW(DM_AW),
                  .LEN_W(LEN_W), .SRST_CYC(SRST_CYC)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dm_en(dm_en), .dm_we(dm_we),
    .dm_addr(dm_addr), .dm_wdata(dm_wdata), .dm_rdata(dm_rdata),
    .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .xfer_done(xfer_done), .xfer_done_len(xfer_done_len), .irq(irq)
  );

  logic [31:0] mem [64];
  always @(posedge clk) begin
    if (dm_en) begin
      if (dm_we) mem[dm_addr] <= dm_wdata;
      else dm_rdata <= mem[dm_addr];
    end
  end

  int n_chk = 0, n_fail = 0, n_x = 0, resp_delay = 2, rst_acc = 0;
  logic [31:0] lg_addr [16];
  logic [LEN_W-1:0] lg_len [16];
  logic [31:0] cp_sw = '0;

  always @(negedge clk) if (rst && dm_en) rst_acc++;

  // data-mover model
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && xfer_req && !xfer_done) begin
        if (n_x < 16) begin
          lg_addr[n_x] = xfer_addr;
          lg_len[n_x] = xfer_len;
        end
        n_x++;
        repeat (resp_delay) @(negedge clk);
        xfer_done = 1'b1;
        xfer_done_len = xfer_len[10:0] - 11'd1;
        @(negedge clk);
        xfer_done = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mkdesc(input int a, input logic [31:0] nxt, input logic [31:0] b,
                        input logic [31:0] l, input logic [31:0] m);
    mem[a] = nxt; mem[a+1] = b; mem[a+2] = l; mem[a+3] = m;
  endtask

  function automatic logic [31:0] exp_wb(input logic [31:0] orig, input logic [31:0] l,
                                         input bit last);
    logic [10:0] rep;
    logic [31:0] r;
    rep = (l[10:0] - 11'd1) + (orig[26] ? 11'd4 : 11'd0);
    r = {orig[31:11], rep};
    r[29] = 1'b0;
    if (last) r[28] = 1'b1;
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, m0, m1, m2;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 xfer_req", {31'd0, xfer_req}, 32'd0);
    chk("R1 no mem access in reset", rst_acc, 0);
    rd(3'd0, v); chk("R1 txctl", v, 0);
    rd(3'd2, v); chk("R1 head", v, 0);
    rd(3'd3, v); chk("R1 compl", v, 0);
    rd(3'd5, v); chk("R1 srst", v, 0);

    // R2 enable gating by direction
    m0 = SE | OWN | 32'h0004_0055;
    mkdesc(4, 0, 32'hA000_0000, 32'd100, m0);
    wr(3'd1, 32'd1);
    wr(3'd2, 32'd4);
    wait_cyc(30);
    chk("R2 other direction starts nothing", n_x, 0);
    chk("R2 descriptor untouched", mem[7], m0);
    rd(3'd2, v); chk("R2 head held while disabled", v, 4);
    wr(3'd0, 32'd1);
    wait_cyc(30);
    chk("R2 runs once enabled", n_x, 1);
    chk("R2 writeback", mem[7], exp_wb(m0, 100, 1));
    chk("R9 irq after finish", {31'd0, irq}, 32'd1);
    wr(3'd3, 32'd4); cp_sw = 4;
    wait_cyc(3);
    chk("R9 irq cleared by ack", {31'd0, irq}, 32'd0);

    // R3 R4 R5 R9 sweep over chain length and length patterns
    for (int n = 1; n <= 4; n++) begin
      for (int vv = 0; vv < 2; vv++) begin
        logic [31:0] ln [4];
        logic [31:0] md [4];
        n_x = 0;
        for (int i = 0; i < n; i++) begin
          ln[i] = (vv == 0) ? 32'(64 + 13*i + n) : ((i == 0) ? 32'd0 : 32'(2040 + i));
          md[i] = SE | OWN | (((i + vv) % 2 == 1) ? CRC : 32'd0) | 32'h0004_005A;
          mkdesc(4 + 4*i, (i < n-1) ? 32'(8 + 4*i) : 32'd0,
                 32'h1000_0000 * 32'(n) + 32'(vv*256 + i*16), ln[i], md[i]);
        end
        wr(3'd2, 32'd4);
        wait_cyc(15*n + 20);
        chk("R5 chain length followed", n_x, n);
        for (int i = 0; i < n; i++) begin
          chk("R3 xfer_addr", lg_addr[i], 32'h1000_0000 * 32'(n) + 32'(vv*256 + i*16));
          chk("R3 xfer_len", {16'd0, lg_len[i]}, ln[i]);
          chk("R4 R5 status writeback", mem[4 + 4*i + 3], exp_wb(md[i], ln[i], i == n-1));
        end
        rd(3'd2, v); chk("R5 head zero at end", v, 0);
        chk("R9 irq vs ack", {31'd0, irq}, {31'd0, cp_sw != 32'(4 + 4*(n-1))});
        wr(3'd3, 32'(4 + 4*(n-1))); cp_sw = 32'(4 + 4*(n-1));
        wait_cyc(3);
        chk("R9 irq low after ack", {31'd0, irq}, 32'd0);
      end
    end

    // R6 owner clear stops walk, R7 restart
    n_x = 0;
    m0 = SE | OWN | 32'h0000_0011;
    m1 = SE | 32'h0000_0022;
    mkdesc(4, 8, 32'hB000_0000, 32'd50, m0);
    mkdesc(8, 0, 32'hB000_0100, 32'd60, m1);
    wr(3'd2, 32'd4);
    wait_cyc(40);
    chk("R6 not transferred", n_x, 1);
    chk("R6 EOQ on previous", mem[7], exp_wb(m0, 50, 0) | EOQ);
    chk("R6 unowned untouched", mem[11], m1);
    rd(3'd2, v); chk("R6 head cleared", v, 0);
    mem[11] = m1 | OWN;
    wr(3'd2, 32'd8);
    wait_cyc(30);
    chk("R7 restart transfers", n_x, 2);
    chk("R7 restart addr", lg_addr[1], 32'hB000_0100);
    chk("R7 restart writeback", mem[11], exp_wb(m1 | OWN, 60, 1));
    wr(3'd3, 32'd8); cp_sw = 8;

    // R8 wrong id ignored, R11 head write while busy ignored
    resp_delay = 20;
    n_x = 0;
    m0 = SE | OWN | 32'h0000_0001;
    m1 = SE | OWN | CRC | 32'h0000_0002;
    m2 = SE | OWN | 32'h0000_0003;
    mkdesc(4, 8, 32'hC000_0000, 32'd70, m0);
    mkdesc(8, 0, 32'hC000_0100, 32'd80, m1);
    mkdesc(40, 0, 32'hDEAD_0000, 32'd90, m2);
    wr(3'd2, 32'd4);
    while (!xfer_req) @(negedge clk);
    wr(3'd4, 32'd5);
    wr(3'd2, 32'd40);
    wait_cyc(150);
    chk("R8 wrong id: both done", n_x, 2);
    chk("R8 wrong id: normal status", mem[7], exp_wb(m0, 70, 0));
    chk("R8 wrong id: normal last", mem[11], exp_wb(m1, 80, 1));
    chk("R11 busy head write ignored", mem[43], m2);
    rd(3'd3, v); chk("R8 wrong id: compl unchanged", v, 8);
    wr(3'd3, 32'd8); cp_sw = 8;

    // R8 teardown during a transfer
    n_x = 0;
    mkdesc(4, 8, 32'hC000_0000, 32'd70, m0);
    mkdesc(8, 0, 32'hC000_0100, 32'd80, m1);
    wr(3'd2, 32'd4);
    while (!xfer_req) @(negedge clk);
    wr(3'd4, 32'(CHAN_ID));
    wait_cyc(80);
    chk("R8 only current transferred", n_x, 1);
    chk("R8 teardown status", mem[7], exp_wb(m0, 70, 0) | TDC | EOQ);
    chk("R8 next untouched", mem[11], m1);
    rd(3'd3, v); chk("R8 compl magic", v, 32'hFFFF_FFFC);
    rd(3'd2, v); chk("R8 head cleared", v, 0);
    chk("R9 irq after teardown", {31'd0, irq}, 32'd1);

    // R8 teardown with empty queue
    wr(3'd3, 32'd0);
    wr(3'd4, 32'(CHAN_ID));
    wait_cyc(5);
    rd(3'd3, v); chk("R8 empty queue compl magic", v, 32'hFFFF_FFFC);

    // R10 soft reset
    wr(3'd5, 32'd1);
    rd(3'd5, v); chk("R10 busy reads 1", v, 1);
    wait_cyc(10);
    rd(3'd5, v); chk("R10 done reads 0", v, 0);
    rd(3'd0, v); chk("R10 txctl cleared", v, 0);
    rd(3'd3, v); chk("R10 compl cleared", v, 0);
    rd(3'd2, v); chk("R10 head cleared", v, 0);
    chk("R10 irq low", {31'd0, irq}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule